// File: doc/BRIEF.md
# Front-end trigger sequencer

The sequencer produces the timing pulses that drive an analog front-end chip: a trigger, an optional test pulse, an optional front-end reset and a record-start marker for the capture logic. Each accepted event comes from one of two sources. The first is an external trigger line, which is corrected for polarity, synchronized and edge detected. The second is an internal generator that fires at a fixed repetition rate. An event is accepted only while readout is enabled.

A single period setting, scaled by 64 clock cycles, serves both sources. With the external source it sets a deadtime after each accepted trigger, during which further edges are dropped. With the internal source it sets the spacing of the generated triggers. The trigger, test pulse and record start each run their own countdown from the same accepted event, so they can be placed independently. The block also reports how many time samples the front end reads out per trigger, derived from the burst setting.

Configuration is held in registers loaded through a simple write strobe with a select code. Every register comes out of reset at a usable default. The clock is the 25 ns front-end clock.

Top module: `trig_seq`

## Requirements
- R1: Mode bit 0 set makes each accepted event raise fe_reset for one cycle. Mode bit 1 set lets each accepted event start the test-pulse countdown. With either bit clear, the matching output stays low.
- R2: With mode bit 2 clear (internal source) and readout enabled, triggers are generated every PERIOD*64 cycles, and the first one comes in the first cycle after the switch to internal.
- R3: With mode bit 2 set (external source), an accepted event blocks acceptance for exactly PERIOD*64 cycles. A rising edge that reaches the synchronizer 127 cycles after the previous accepted one is ignored when PERIOD is 2; one that arrives 128 cycles after is accepted.
- R4: Mode bit 3 inverts the external line before synchronization. When it is set, a falling edge on ext_trig triggers and a rising edge does not.
- R5: Count clock edges from the first edge that samples an active external edge. fe_reset rises on the 3rd edge. fe_trig rises on edge TRGDELAY+4, fe_tpulse on edge TPDELAY+4 and rec_start on edge ROSYNC+4. Each pulse lasts one cycle.
- R6: After reset, mode is 0x4, PERIOD is 40000, TRGDELAY is 256, TPDELAY is 128, ROSYNC is 300 and burst is 4. All outputs are low during reset.
- R7: No event is accepted while ro_enable is 0, and a rejected edge does not start the deadtime.
- R8: sample_count equals (n+1)*3 for burst setting n, with n clamped to 9, so any n of 9 or more gives 30.
- R9: A countdown that is still running when a new event is accepted is not restarted, so that event produces no pulse on that output.
- R10: A write takes effect on the clock edge where cfg_wr is high. cfg_sel picks the target: 0 mode (low 4 bits), 1 burst (low 8 bits), 2 PERIOD, 3 TRGDELAY, 4 TPDELAY, 5 ROSYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_data | input | 16 | Write data |
| ext_trig | input | 1 | Asynchronous external trigger line |
| ro_enable | input | 1 | Readout enable; events accepted only while high |
| fe_trig | output | 1 | Trigger pulse to the front end |
| fe_tpulse | output | 1 | Test-pulse strobe |
| fe_reset | output | 1 | Front-end reset pulse |
| rec_start | output | 1 | Start-of-recording pulse |
| sample_count | output | 5 | Time samples read out per trigger |

## Verification
A deadtime counter that is wrong by one cycle shows up at the ports only on the boundary pair of edges, 127 against 128 cycles apart, so both of them are driven. A countdown lane that is stuck busy or starts late moves or removes its pulse within the next delay window. The check compares the absolute cycle of each pulse against a count taken from the external edge. A wrong internal generator reload shows up in the spacing between the second and third generated triggers.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int CFG_W       = 16;
    localparam int MODE_W      = 4;
    localparam int BURST_W     = 8;
    localparam int SCALE_SHIFT = 6;
    localparam int CNT_W       = CFG_W + SCALE_SHIFT;
    localparam int SAMP_W      = 5;
    localparam int BURST_MAX   = 9;
    localparam int N_LANE      = 3;

    localparam int MB_FERST  = 0;
    localparam int MB_TPEN   = 1;
    localparam int MB_EXTSRC = 2;
    localparam int MB_INV    = 3;

    localparam int LANE_TRG = 0;
    localparam int LANE_TP  = 1;
    localparam int LANE_REC = 2;

    localparam logic [MODE_W-1:0]  DEF_MODE   = 4'h4;
    localparam logic [BURST_W-1:0] DEF_BURST  = 8'd4;
    localparam logic [CFG_W-1:0]   DEF_PERIOD = 16'd40000;
    localparam logic [CFG_W-1:0]   DEF_TRGDLY = 16'd256;
    localparam logic [CFG_W-1:0]   DEF_TPDLY  = 16'd128;
    localparam logic [CFG_W-1:0]   DEF_ROSYNC = 16'd300;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_BURST  = 3'd1,
        SEL_PERIOD = 3'd2,
        SEL_TRGDLY = 3'd3,
        SEL_TPDLY  = 3'd4,
        SEL_ROSYNC = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [BURST_W-1:0] burst;
        logic [CFG_W-1:0]   period;
        logic [CFG_W-1:0]   trg_dly;
        logic [CFG_W-1:0]   tp_dly;
        logic [CFG_W-1:0]   ro_dly;
    } seq_cfg_t;

    // Samples per trigger from the burst setting, clamped at the maximum.
    function automatic logic [SAMP_W-1:0] samples_of(logic [BURST_W-1:0] n);
        logic [BURST_W-1:0] c;
        c = (n > BURST_W'(BURST_MAX)) ? BURST_W'(BURST_MAX) : n;
        return SAMP_W'(c * BURST_W'(3) + BURST_W'(3));
    endfunction

    // Counter reload for a window of period*64 cycles (terminal value zero).
    function automatic logic [CNT_W-1:0] window_load(logic [CFG_W-1:0] p);
        if (p == '0) return '0;
        return {p, {SCALE_SHIFT{1'b0}}} - CNT_W'(1);
    endfunction

endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
    import trig_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [2:0]       sel,
    input  logic [CFG_W-1:0] data,
    output seq_cfg_t         cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode    <= DEF_MODE;
            cfg_q.burst   <= DEF_BURST;
            cfg_q.period  <= DEF_PERIOD;
            cfg_q.trg_dly <= DEF_TRGDLY;
            cfg_q.tp_dly  <= DEF_TPDLY;
            cfg_q.ro_dly  <= DEF_ROSYNC;
        end else if (wr) begin
            case (cfg_sel_e'(sel))
                SEL_MODE:   cfg_q.mode    <= data[MODE_W-1:0];
                SEL_BURST:  cfg_q.burst   <= data[BURST_W-1:0];
                SEL_PERIOD: cfg_q.period  <= data;
                SEL_TRGDLY: cfg_q.trg_dly <= data;
                SEL_TPDLY:  cfg_q.tp_dly  <= data;
                SEL_ROSYNC: cfg_q.ro_dly  <= data;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/trig_seq_src.sv
module trig_seq_src
    import trig_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_trig,
    input  logic             ro_enable,
    input  logic             ext_src,
    input  logic             invert,
    input  logic [CFG_W-1:0] period,
    output logic             accept
);

    logic             sync1, sync2, sync3;
    logic             ext_edge;
    logic [CNT_W-1:0] gen_cnt;
    logic             gen_tick;
    logic [CNT_W-1:0] dead_cnt;
    logic             candidate;
    logic [CNT_W-1:0] reload;

    assign reload = window_load(period);

    // Polarity correction ahead of a two-flop synchronizer, then edge detect.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= ext_trig ^ invert;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign ext_edge = sync2 & ~sync3;

    // Internal generator: parked at zero while the external source is chosen.
    always_ff @(posedge clk) begin
        if (rst || ext_src) begin
            gen_cnt <= '0;
        end else if (gen_cnt == '0) begin
            gen_cnt <= reload;
        end else begin
            gen_cnt <= gen_cnt - CNT_W'(1);
        end
    end

    assign gen_tick  = ~ext_src & (gen_cnt == '0);
    assign candidate = ext_src ? ext_edge : gen_tick;
    assign accept    = candidate & ro_enable & (dead_cnt == '0);

    // Deadtime window, started only by an accepted event.
    always_ff @(posedge clk) begin
        if (rst) begin
            dead_cnt <= '0;
        end else if (accept) begin
            dead_cnt <= reload;
        end else if (dead_cnt != '0) begin
            dead_cnt <= dead_cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/trig_seq_dly.sv
module trig_seq_dly #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dly,
    output logic         pulse
);

    logic         busy;
    logic [W-1:0] cnt;

    // A start while busy is dropped; the running countdown is kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    pulse <= 1'b1;
                    busy  <= 1'b0;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= dly;
            end
        end
    end

endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              ext_trig,
    input  logic              ro_enable,
    output logic              fe_trig,
    output logic              fe_tpulse,
    output logic              fe_reset,
    output logic              rec_start,
    output logic [SAMP_W-1:0] sample_count
);

    seq_cfg_t          cfg_q;
    logic [MODE_W-1:0] mode_q;
    logic [CFG_W-1:0]  period_q;
    logic              accept;
    logic [N_LANE-1:0] lane_start;
    logic [N_LANE-1:0] lane_pulse;
    logic [CFG_W-1:0]  lane_dly [N_LANE];

    trig_seq_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .data  (cfg_data),
        .cfg_q (cfg_q)
    );

    assign mode_q   = cfg_q.mode;
    assign period_q = cfg_q.period;

    trig_seq_src u_src (
        .clk       (clk),
        .rst       (rst),
        .ext_trig  (ext_trig),
        .ro_enable (ro_enable),
        .ext_src   (mode_q[MB_EXTSRC]),
        .invert    (mode_q[MB_INV]),
        .period    (period_q),
        .accept    (accept)
    );

    assign lane_start[LANE_TRG] = accept;
    assign lane_start[LANE_TP]  = accept & mode_q[MB_TPEN];
    assign lane_start[LANE_REC] = accept;
    assign lane_dly[LANE_TRG]   = cfg_q.trg_dly;
    assign lane_dly[LANE_TP]    = cfg_q.tp_dly;
    assign lane_dly[LANE_REC]   = cfg_q.ro_dly;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        trig_seq_dly #(.W(CFG_W)) u_dly (
            .clk   (clk),
            .rst   (rst),
            .start (lane_start[g]),
            .dly   (lane_dly[g]),
            .pulse (lane_pulse[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) fe_reset <= 1'b0;
        else     fe_reset <= accept & mode_q[MB_FERST];
    end

    assign fe_trig      = lane_pulse[LANE_TRG];
    assign fe_tpulse    = lane_pulse[LANE_TP];
    assign rec_start    = lane_pulse[LANE_REC];
    assign sample_count = samples_of(cfg_q.burst);

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
    import trig_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input logic [MODE_W-1:0] mode,
    input logic [CFG_W-1:0]  period,
    input logic              ro_enable,
    input logic              fe_trig,
    input logic              fe_tpulse,
    input logic              fe_reset,
    input logic [SAMP_W-1:0] sample_count
);

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) fe_trig |=> !fe_trig); // R5
    AST_TP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) fe_tpulse |=> !fe_tpulse); // R5
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst) (accept && period != '0) |=> !accept); // R3
    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst) accept |-> ro_enable); // R7
    AST_RESET_PULSE_MODE: assert property (@(posedge clk) disable iff (rst) fe_reset |-> ($past(accept) && $past(mode[MB_FERST]))); // R1
    AST_SAMPLES_LEGAL: assert property (@(posedge clk) disable iff (rst) (sample_count >= 5'd3 && sample_count <= 5'd30 && (sample_count % 5'd3) == 5'd0)); // R8

endmodule

bind trig_seq trig_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .mode         (mode_q),
    .period       (period_q),
    .ro_enable    (ro_enable),
    .fe_trig      (fe_trig),
    .fe_tpulse    (fe_tpulse),
    .fe_reset     (fe_reset),
    .sample_count (sample_count)
);

// File: tb/trig_seq_tb_top.sv
`timescale 1ns/1ps
module trig_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_data = 16'd0;
    logic        ext_trig = 1'b0;
    logic        ro_enable = 1'b0;
    logic        fe_trig, fe_tpulse, fe_reset, rec_start;
    logic [4:0]  sample_count;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int trig_n, tp_n, rst_n, rec_n;
    int trig_at [16];
    int tp_at [16];
    int rst_at [16];
    int rec_at [16];

    localparam int NV = 6;
    localparam int VEC [NV][2] = '{'{0, 3}, '{1, 6}, '{4, 15}, '{9, 30}, '{10, 30}, '{255, 30}};

    trig_seq dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .ext_trig(ext_trig), .ro_enable(ro_enable), .fe_trig(fe_trig), .fe_tpulse(fe_tpulse),
        .fe_reset(fe_reset), .rec_start(rec_start), .sample_count(sample_count)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (fe_trig)   begin if (trig_n < 16) trig_at[trig_n] = cyc; trig_n++; end
            if (fe_tpulse) begin if (tp_n < 16) tp_at[tp_n] = cyc; tp_n++; end
            if (fe_reset)  begin if (rst_n < 16) rst_at[rst_n] = cyc; rst_n++; end
            if (rec_start) begin if (rec_n < 16) rec_at[rec_n] = cyc; rec_n++; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        trig_n = 0; tp_n = 0; rst_n = 0; rec_n = 0;
        for (int i = 0; i < 16; i++) begin
            trig_at[i] = -1; tp_at[i] = -1; rst_at[i] = -1; rec_at[i] = -1;
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_until(input int t);
        do @(negedge clk); while (cyc < t);
        #1;
    endtask

    task automatic write_cfg(input logic [2:0] sel, input logic [15:0] d);
        step();
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        step();
        cfg_wr = 1'b0;
    endtask

    // Drive the active level at cycle t, hold 4 cycles, return to idle.
    task automatic pulse_at(input int t, input logic active);
        wait_until(t);
        ext_trig = active;
        repeat (4) step();
        ext_trig = ~active;
    endtask

    task automatic do_reset();
        step();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        clear_log();
    endtask

    initial begin
        #(100000 * 4);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual %0d expected 0", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int c;
        clear_log();
        repeat (3) step();
        // R6: reset state
        check("R6 outputs low in reset", int'({fe_trig, fe_tpulse, fe_reset, rec_start}), 0);
        check("R6 default burst samples", int'(sample_count), 15);
        rst = 1'b0;
        step();

        // R8 / R10: burst table
        for (int i = 0; i < NV; i++) begin
            write_cfg(3'd1, 16'(VEC[i][0]));
            check("R8 R10 samples for burst", int'(sample_count), VEC[i][1]);
        end
        write_cfg(3'd1, 16'd4);

        // R6 / R5 / R1: default delays, only mode changed
        ro_enable = 1'b1;
        write_cfg(3'd0, 16'h0007);
        clear_log();
        c = cyc + 2;
        pulse_at(c, 1'b1);
        wait_until(c + 400);
        check("R1 reset pulse cycle", rst_at[0], c + 3);
        check("R6 default tp delay", tp_at[0], c + 132);
        check("R6 default trigger delay", trig_at[0], c + 260);
        check("R6 default record delay", rec_at[0], c + 304);
        check("R5 single trigger pulse", trig_n, 1);

        // Shorter timing for the remaining tests
        do_reset();
        ro_enable = 1'b1;
        write_cfg(3'd2, 16'd2);
        write_cfg(3'd3, 16'd10);
        write_cfg(3'd4, 16'd5);
        write_cfg(3'd5, 16'd20);
        write_cfg(3'd0, 16'h0006);

        // R3: edge 127 cycles later ignored
        clear_log();
        c = cyc + 2;
        pulse_at(c, 1'b1);
        pulse_at(c + 127, 1'b1);
        wait_until(c + 400);
        check("R3 edge inside deadtime ignored", trig_n, 1);
        check("R5 trigger delay", trig_at[0], c + 14);
        check("R5 tp delay", tp_at[0], c + 9);
        check("R5 record delay", rec_at[0], c + 24);
        check("R1 no reset pulse with bit0 clear", rst_n, 0);

        // R3: edge 128 cycles later accepted
        clear_log();
        c = cyc + 2;
        pulse_at(c, 1'b1);
        pulse_at(c + 128, 1'b1);
        wait_until(c + 400);
        check("R3 edge at deadtime end count", trig_n, 2);
        check("R3 edge at deadtime end cycle", trig_at[1], c + 128 + 14);

        // R7: disabled readout
        clear_log();
        ro_enable = 1'b0;
        c = cyc + 2;
        pulse_at(c, 1'b1);
        wait_until(c + 50);
        ro_enable = 1'b1;
        pulse_at(c + 60, 1'b1);
        wait_until(c + 400);
        check("R7 disabled edge dropped, no deadtime", trig_n, 1);
        check("R7 next edge accepted at once", trig_at[0], c + 74);

        // R4: inverted polarity
        ro_enable = 1'b0;
        step();
        ext_trig = 1'b1;
        repeat (10) step();
        write_cfg(3'd0, 16'h000C);
        repeat (10) step();
        ro_enable = 1'b1;
        repeat (10) step();
        clear_log();
        c = cyc + 2;
        wait_until(c);
        ext_trig = 1'b0;
        wait_until(c + 200);
        ext_trig = 1'b1;
        wait_until(c + 500);
        check("R4 falling edge triggers", trig_at[0], c + 14);
        check("R4 rising edge ignored", trig_n, 1);
        check("R1 no tp with bit1 clear", tp_n, 0);
        ro_enable = 1'b0;
        write_cfg(3'd0, 16'h0006);
        step();
        ext_trig = 1'b0;
        repeat (10) step();
        ro_enable = 1'b1;

        // R2: internal generator
        repeat (200) step();
        clear_log();
        write_cfg(3'd0, 16'h0002);
        repeat (450) step();
        write_cfg(3'd0, 16'h0006);
        repeat (300) step();
        check("R2 internal triggers generated", int'(trig_n >= 3), 1);
        check("R2 internal spacing first", trig_at[1] - trig_at[0], 128);
        check("R2 internal spacing second", trig_at[2] - trig_at[1], 128);

        // R9: busy countdown not restarted
        write_cfg(3'd2, 16'd1);
        write_cfg(3'd3, 16'd100);
        repeat (200) step();
        clear_log();
        c = cyc + 2;
        pulse_at(c, 1'b1);
        pulse_at(c + 70, 1'b1);
        wait_until(c + 400);
        check("R9 busy trigger lane not restarted", trig_n, 1);
        check("R9 trigger from first event", trig_at[0], c + 104);
        check("R9 idle tp lane fires twice", tp_n, 2);
        check("R9 second tp cycle", tp_at[1], c + 79);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule